// File: doc/BRIEF.md
# Virtual-Channel Conversion Scheduler

This block sits between software and two analog-to-digital converter cores. Software sees sixteen virtual channels. Each channel has a configuration word that can enable core 1, core 2 or both, and that picks one of eight inputs on each enabled core. To request a conversion, software sets that channel's bit in a pending-request word. It uses a write-one-to-set alias to do so. Completion shows up as the bit clearing by itself, so software polls the request word until the bit drops and then reads the 12-bit result that was stored for that channel and core.

A fixed-priority scheduler serves one pending channel at a time, and only while the converter is idle. The converter clock is an enable pulse taken from the bus clock every `CONV_DIV` bus cycles. A conversion lasts `CONV_TICKS` of those pulses. A power-down bit starts a timed power transition, and a busy flag stays high until the transition ends. While the block is powered down or busy it grants nothing and refuses new requests. Requests that were already pending stay pending. The cores are behavioural stubs: each one captures the selected 12-bit input word at the moment its conversion is granted.

Top module: `vcadc_sched`

## Requirements
- R1: Channel n's configuration word is at byte address 0x0C0+4n. Bits [2:0] select the core-1 input, bits [5:3] select the core-2 input, bit 15 enables core 1 and bit 16 enables core 2. All other bits read back as 0.
- R2: The pending word reads at 0x030, with bit n for channel n. A write to 0x034 sets every bit written as 1, and a write to 0x038 clears every bit written as 1. Bits written as 0 leave their channels unchanged.
- R3: When the converter is idle, the lowest-numbered pending channel is granted on the next clock. A conversion in progress is never replaced by a newly pending channel of higher priority.
- R4: A granted conversion lasts `CONV_TICKS` converter pulses, one pulse every `CONV_DIV` bus clocks. The channel's pending bit clears on the clock edge where the conversion ends.
- R5: Results are 12 bits in [11:0], and the upper bits read 0. The core-1 result of channel n is at 0x100+4n and the core-2 result is at 0x140+4n. Each holds the selected input word as it was on the grant cycle.
- R6: A channel with both cores enabled converts on both cores at once. Both result registers update on the same edge that clears its pending bit.
- R7: A granted channel with neither core enabled has its pending bit cleared on the grant edge, and no result register changes.
- R8: Bit 3 at 0x040 is the power-down flag. Any write to 0x040 makes bit 6 at 0x02C read 1 for exactly `BUSY_CYC` cycles.
- R9: While powered down or busy, writes to the set alias are ignored and no channel is granted. Bits that were pending stay set, and they are served once the block is powered up and not busy.
- R10: Clearing the bit of the channel being converted aborts that conversion, and its result registers keep their old values.
- R11: After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW (9) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core1_ain | input | 8*DW (96) | Core-1 input words, with input k at [k*DW +: DW] |
| core2_ain | input | 8*DW (96) | Core-2 input words, with input k at [k*DW +: DW] |

## Verification
The scheduler is exercised with several request patterns: a single channel on one core, a channel using both cores, a channel with no core enabled, two requests set together plus a higher-priority one that arrives mid-conversion, and an abort through the clear alias. Each pattern separates a different fault. The single-channel case exposes errors in conversion length and input selection. The dual-core case catches a core that never writes. The empty channel distinguishes skipping from hanging. The late high-priority request tells plain priority order apart from pre-emption. The power sequence mixes a conversion already running, a request already pending and a request refused during power-down. It shows that the power gate blocks grants and new requests but neither drops pending work nor stops the conversion in flight. A behavioural model compares the readback of whatever address is on the bus on every cycle, so an off-by-one in the pulse divider or the busy length shows up at once.

// File: rtl/vcadc_pkg.sv
package vcadc_pkg;

  localparam int SEL_W      = 3;
  localparam int BUSY_BIT   = 6;
  localparam int PD_BIT     = 3;
  localparam int ADR_CTRL   = 'h02C;
  localparam int ADR_PEND   = 'h030;
  localparam int ADR_PSET   = 'h034;
  localparam int ADR_PCLR   = 'h038;
  localparam int ADR_PWR    = 'h040;
  localparam int ADR_CFG    = 'h0C0;
  localparam int ADR_RES1   = 'h100;
  localparam int ADR_RES2   = 'h140;

  typedef struct packed {
    logic             en2;
    logic             en1;
    logic [SEL_W-1:0] sel2;
    logic [SEL_W-1:0] sel1;
  } vc_cfg_t;

  function automatic vc_cfg_t cfg_unpack(input logic [31:0] w);
    vc_cfg_t c;
    c.sel1 = w[2:0];
    c.sel2 = w[5:3];
    c.en1  = w[15];
    c.en2  = w[16];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input vc_cfg_t c);
    logic [31:0] w;
    w       = '0;
    w[2:0]  = c.sel1;
    w[5:3]  = c.sel2;
    w[15]   = c.en1;
    w[16]   = c.en2;
    return w;
  endfunction

endpackage

// File: rtl/vcadc_arb.sv
module vcadc_arb #(
  parameter int NCH = 16,
  localparam int IDXW = $clog2(NCH)
) (
  input  logic [NCH-1:0]  req,
  input  logic            allow,
  output logic            grant_vld,
  output logic [IDXW-1:0] grant_idx
);
  always_comb begin
    grant_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) grant_idx = IDXW'(i);
    end
    grant_vld = allow && (|req);
  end
endmodule

// File: rtl/vcadc_conv_timer.sv
module vcadc_conv_timer #(
  parameter int CONV_DIV   = 2,
  parameter int CONV_TICKS = 20,
  localparam int DIVW = $clog2(CONV_DIV + 1),
  localparam int CNTW = $clog2(CONV_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic active,
  output logic tick,
  output logic last_tick
);
  logic [DIVW-1:0] div_q;
  logic [CNTW-1:0] cnt_q;

  assign tick      = (div_q == DIVW'(CONV_DIV - 1));
  assign last_tick = active && tick && (cnt_q == CNTW'(CONV_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      active <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (start) begin
        active <= 1'b1;
        cnt_q  <= '0;
      end else if (stop || last_tick) begin
        active <= 1'b0;
      end else if (active && tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vcadc_core.sv
module vcadc_core #(
  parameter int DW   = 12,
  parameter int SELW = 3,
  localparam int NIN = 1 << SELW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [SELW-1:0]   sel,
  input  logic [NIN*DW-1:0] ain,
  output logic [DW-1:0]     sample
);
  always_ff @(posedge clk) begin
    if (!rst_n) sample <= '0;
    else if (capture) sample <= ain[int'(sel)*DW +: DW];
  end
endmodule

// File: rtl/vcadc_pwr.sv
module vcadc_pwr #(
  parameter int BUSY_CYC = 8,
  localparam int BW = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic pd_in,
  output logic pd,
  output logic busy
);
  logic [BW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd     <= 1'b0;
      left_q <= '0;
    end else if (wr) begin
      pd     <= pd_in;
      left_q <= BW'(BUSY_CYC);
    end else if (busy) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/vcadc_sched.sv
module vcadc_sched
  import vcadc_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int DW         = 12,
  parameter int CONV_DIV   = 2,
  parameter int CONV_TICKS = 20,
  parameter int BUSY_CYC   = 8,
  parameter int AW         = 9,
  localparam int NIN  = 1 << SEL_W,
  localparam int IDXW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NIN*DW-1:0] core1_ain,
  input  logic [NIN*DW-1:0] core2_ain
);
  localparam int RLO = IDXW + 2;

  logic [NCH-1:0]  force_q;
  vc_cfg_t         cfg_q   [NCH];
  logic [DW-1:0]   res1_q  [NCH];
  logic [DW-1:0]   res2_q  [NCH];
  logic [IDXW-1:0] cur_q;
  logic            use1_q, use2_q;

  logic            pd, busy;
  logic            conv_active, conv_tick, last_tick;
  logic            grant_vld;
  logic [IDXW-1:0] grant_idx;
  vc_cfg_t         gcfg;
  logic            conv_start, conv_skip, conv_done, conv_abort;
  logic            set_hit, clr_hit, pwr_hit, cfg_hit;
  logic [NCH-1:0]  set_mask, clr_mask, auto_clr;
  logic [IDXW-1:0] widx;
  logic [DW-1:0]   smp [2];
  logic            unused_wdata_hi;

  assign unused_wdata_hi = ^{bus_wdata[31:17], conv_tick};

  // bus decode
  assign widx    = bus_addr[RLO-1:2];
  assign set_hit = bus_wr && (bus_addr == AW'(ADR_PSET));
  assign clr_hit = bus_wr && (bus_addr == AW'(ADR_PCLR));
  assign pwr_hit = bus_wr && (bus_addr == AW'(ADR_PWR));
  assign cfg_hit = bus_wr && (bus_addr[AW-1:RLO] == ADR_CFG[AW-1:RLO]);

  assign set_mask = (set_hit && !pd && !busy) ? bus_wdata[NCH-1:0] : '0;
  assign clr_mask = clr_hit ? bus_wdata[NCH-1:0] : '0;

  vcadc_pwr #(.BUSY_CYC(BUSY_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .wr(pwr_hit), .pd_in(bus_wdata[PD_BIT]),
    .pd(pd), .busy(busy)
  );

  vcadc_arb #(.NCH(NCH)) u_arb (
    .req(force_q), .allow(!conv_active && !pd && !busy),
    .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  assign gcfg       = cfg_q[grant_idx];
  assign conv_start = grant_vld && (gcfg.en1 || gcfg.en2);
  assign conv_skip  = grant_vld && !(gcfg.en1 || gcfg.en2);
  assign conv_abort = conv_active && clr_mask[cur_q];
  assign conv_done  = last_tick && !conv_abort;

  vcadc_conv_timer #(.CONV_DIV(CONV_DIV), .CONV_TICKS(CONV_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .stop(conv_abort),
    .active(conv_active), .tick(conv_tick), .last_tick(last_tick)
  );

  for (genvar k = 0; k < 2; k++) begin : g_core
    vcadc_core #(.DW(DW), .SELW(SEL_W)) u_core (
      .clk(clk), .rst_n(rst_n), .capture(conv_start),
      .sel((k == 0) ? gcfg.sel1 : gcfg.sel2),
      .ain((k == 0) ? core1_ain : core2_ain),
      .sample(smp[k])
    );
  end

  always_comb begin
    auto_clr = '0;
    if (conv_done) auto_clr[cur_q]     = 1'b1;
    if (conv_skip) auto_clr[grant_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q <= '0;
      cur_q   <= '0;
      use1_q  <= 1'b0;
      use2_q  <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        cfg_q[i]  <= '0;
        res1_q[i] <= '0;
        res2_q[i] <= '0;
      end
    end else begin
      force_q <= ((force_q & ~auto_clr) | set_mask) & ~clr_mask;
      if (cfg_hit) cfg_q[widx] <= cfg_unpack(bus_wdata);
      if (conv_start) begin
        cur_q  <= grant_idx;
        use1_q <= gcfg.en1;
        use2_q <= gcfg.en2;
      end
      if (conv_done) begin
        if (use1_q) res1_q[cur_q] <= smp[0];
        if (use2_q) res2_q[cur_q] <= smp[1];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADR_CTRL))      bus_rdata[BUSY_BIT]  = busy;
    else if (bus_addr == AW'(ADR_PEND)) bus_rdata[NCH-1:0]   = force_q;
    else if (bus_addr == AW'(ADR_PWR))  bus_rdata[PD_BIT]    = pd;
    else if (bus_addr[AW-1:RLO] == ADR_CFG[AW-1:RLO])  bus_rdata = cfg_pack(cfg_q[widx]);
    else if (bus_addr[AW-1:RLO] == ADR_RES1[AW-1:RLO]) bus_rdata[DW-1:0] = res1_q[widx];
    else if (bus_addr[AW-1:RLO] == ADR_RES2[AW-1:RLO]) bus_rdata[DW-1:0] = res2_q[widx];
  end
endmodule

// File: rtl/vcadc_sched_chk.sv
module vcadc_sched_chk #(
  parameter int NCH = 16,
  localparam int IDXW = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_start,
  input logic            conv_skip,
  input logic            conv_done,
  input logic            conv_abort,
  input logic            conv_active,
  input logic [IDXW-1:0] cur_q,
  input logic [IDXW-1:0] grant_idx,
  input logic [NCH-1:0]  force_q,
  input logic [NCH-1:0]  set_mask,
  input logic            pd,
  input logic            busy,
  input logic            pwr_hit
);
  // R9
  grant_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (!pd && !busy));

  // R3
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && !conv_done && !conv_abort) |=> (conv_active && cur_q == $past(cur_q)));

  // R3
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, conv_skip, conv_done}));

  // R4
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !set_mask[cur_q]) |=> !force_q[$past(cur_q)]);

  // R7
  skip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_skip && !set_mask[grant_idx]) |=> (!force_q[$past(grant_idx)] && !conv_active));

  // R8
  busy_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_hit |=> busy);

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> !conv_active);
endmodule

bind vcadc_sched vcadc_sched_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_skip(conv_skip),
  .conv_done(conv_done), .conv_abort(conv_abort), .conv_active(conv_active),
  .cur_q(cur_q), .grant_idx(grant_idx), .force_q(force_q), .set_mask(set_mask),
  .pd(pd), .busy(busy), .pwr_hit(pwr_hit)
);

// File: tb/vcadc_sched_tb.sv
module vcadc_sched_tb;
  localparam int NCH = 16, DW = 12, DIV = 2, TICKS = 20, BUSY = 8, AW = 9;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           bus_wr = 0;
  logic [AW-1:0]  bus_addr = 9'h030;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [95:0]    core1_ain, core2_ain;
  int             checks = 0, errors = 0;
  bit             finished = 0;

  always #4 clk = ~clk;

  function automatic logic [11:0] a1(input int k); return 12'(32'h0A1 + k * 32'h111); endfunction
  function automatic logic [11:0] a2(input int k); return 12'(32'h3C5 + k * 32'h0F3); endfunction

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      core1_ain[k*DW +: DW] = a1(k);
      core2_ain[k*DW +: DW] = a2(k);
    end
  end

  vcadc_sched u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core1_ain(core1_ain), .core2_ain(core2_ain));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_div, m_cnt, m_busy, m_cur;
  bit          m_act, m_pd, m_u1, m_u2;
  logic [15:0] m_pend;
  logic [31:0] m_cfg [16];
  logic [11:0] m_r1 [16], m_r2 [16];
  logic [11:0] m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_busy = 0; m_cur = 0; m_act = 0; m_pd = 0;
      m_u1 = 0; m_u2 = 0; m_pend = 0; m_s1 = 0; m_s2 = 0;
      for (int i = 0; i < 16; i++) begin m_cfg[i] = 0; m_r1[i] = 0; m_r2[i] = 0; end
    end else begin
      bit tick, abort;
      logic [15:0] setm, clrm, autoc;
      int a;
      a = int'(bus_addr);
      tick  = (m_div == DIV - 1);
      setm  = (bus_wr && a == 'h34 && !m_pd && m_busy == 0) ? bus_wdata[15:0] : 16'h0;
      clrm  = (bus_wr && a == 'h38) ? bus_wdata[15:0] : 16'h0;
      autoc = 0;
      abort = m_act && clrm[m_cur];
      if (abort) m_act = 0;
      else if (m_act) begin
        if (tick) begin
          if (m_cnt == TICKS - 1) begin
            if (m_u1) m_r1[m_cur] = m_s1;
            if (m_u2) m_r2[m_cur] = m_s2;
            autoc[m_cur] = 1; m_act = 0;
          end else m_cnt++;
        end
      end else if (!m_pd && m_busy == 0 && m_pend != 0) begin
        int g;
        g = 0;
        while (!m_pend[g]) g++;
        if (m_cfg[g][15] || m_cfg[g][16]) begin
          m_act = 1; m_cur = g; m_cnt = 0;
          m_u1 = m_cfg[g][15]; m_u2 = m_cfg[g][16];
          m_s1 = a1(int'(m_cfg[g][2:0])); m_s2 = a2(int'(m_cfg[g][5:3]));
        end else autoc[g] = 1;
      end
      m_pend = ((m_pend & ~autoc) | setm) & ~clrm;
      if (bus_wr && a >= 'hC0 && a < 'h100) m_cfg[(a - 'hC0) / 4] = bus_wdata & 32'h0001_803F;
      if (bus_wr && a == 'h40) begin m_pd = bus_wdata[3]; m_busy = BUSY; end
      else if (m_busy > 0) m_busy--;
      m_div = tick ? 0 : m_div + 1;
    end
  end

  function automatic logic [31:0] m_read(input int a);
    if (a == 'h2C) return (m_busy > 0) ? 32'h40 : 32'h0;
    if (a == 'h30) return {16'h0, m_pend};
    if (a == 'h40) return m_pd ? 32'h8 : 32'h0;
    if (a >= 'hC0 && a < 'h100) return m_cfg[(a - 'hC0) / 4];
    if (a >= 'h100 && a < 'h140) return {20'h0, m_r1[(a - 'h100) / 4]};
    if (a >= 'h140 && a < 'h180) return {20'h0, m_r2[(a - 'h140) / 4]};
    return 0;
  endfunction

  function automatic string m_tag(input int a);
    if (a == 'h2C || a == 'h40) return "R8";
    if (a == 'h30) return "R4";
    if (a >= 'hC0 && a < 'h100) return "R1";
    return "R5";
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) check(m_tag(int'(bus_addr)), bus_rdata, m_read(int'(bus_addr)));
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 9'h030; bus_wdata = 0;
  endtask

  task automatic rd(input int a, input string req, input logic [31:0] exp);
    @(negedge clk); bus_addr = AW'(a); #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic wait_clear(input int bitn, input int limit, output int n);
    n = 0;
    bus_addr = 9'h030; #1;
    while (bus_rdata[bitn] && n < limit) begin @(negedge clk); #1; n++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, t2, t9, t12;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd('h030, "R11", 0); rd('h02C, "R11", 0); rd('h040, "R11", 0);
    rd('h0C0, "R11", 0); rd('h100, "R11", 0); rd('h17C, "R11", 0);

    // R1 field layout
    wr('h0CC, 32'hFFFF_FFFF);
    rd('h0CC, "R1", 32'h0001_803F);

    // R4/R5 single core-1 conversion on channel 5, input 2
    wr('h0D4, 32'h0000_8002);
    wr('h034, 32'h0000_0020);
    wait_clear(5, 200, n);
    checks++;
    if (n < 2 * TICKS - 2 || n > 2 * TICKS + 2) begin
      errors++; $display("FAIL R4 latency actual=%0d expected=%0d..%0d", n, 2*TICKS-2, 2*TICKS+2);
    end
    rd('h114, "R5", {20'h0, a1(2)});
    rd('h154, "R5", 0);

    // R6 both cores on channel 7
    wr('h0DC, 32'h0001_803E);
    wr('h034, 32'h0000_0080);
    wait_clear(7, 200, n);
    rd('h11C, "R6", {20'h0, a1(6)});
    rd('h15C, "R6", {20'h0, a2(7)});

    // R7 channel 4 with no core enabled
    wr('h034, 32'h0000_0010);
    #1 check("R7", bus_rdata, 32'h10);
    @(negedge clk); #1 check("R7", bus_rdata, 32'h0);
    rd('h110, "R7", 0); rd('h150, "R7", 0);

    // R2 set/clear aliases leave other bits alone
    wr('h0EC, 32'h0000_8001);
    wr('h0F8, 32'h0000_8003);
    wr('h0FC, 32'h0001_0008);
    wr('h034, 32'h0000_0800);
    idle(2);
    wr('h034, 32'h0000_C000);
    rd('h030, "R2", 32'h0000_C800);
    wr('h038, 32'h0000_8000);
    rd('h030, "R2", 32'h0000_4800);
    wait_clear(14, 400, n);
    rd('h030, "R2", 0);

    // R3 priority order without pre-emption
    wr('h0C8, 32'h0000_8000);
    wr('h0E4, 32'h0001_0008);
    wr('h0F0, 32'h0000_8003);
    wr('h034, 32'h0000_1200);
    idle(3);
    wr('h034, 32'h0000_0004);
    t2 = -1; t9 = -1; t12 = -1;
    bus_addr = 9'h030;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk); #1;
      if (!bus_rdata[2]  && t2  < 0) t2  = c;
      if (!bus_rdata[9]  && t9  < 0) t9  = c;
      if (!bus_rdata[12] && t12 < 0) t12 = c;
    end
    checks++;
    if (!(t9 >= 0 && t9 < t2 && t2 < t12)) begin
      errors++; $display("FAIL R3 order actual=%0d,%0d,%0d expected=t9<t2<t12", t9, t2, t12);
    end
    rd('h108, "R3", {20'h0, a1(0)});
    rd('h164, "R3", {20'h0, a2(1)});
    rd('h130, "R3", {20'h0, a1(3)});

    // R10 abort of channel 10 on core 2
    wr('h0E8, 32'h0001_0020);
    wr('h034, 32'h0000_0400);
    idle(10);
    wr('h038, 32'h0000_0400);
    idle(60);
    rd('h030, "R10", 0);
    rd('h168, "R10", 0);

    // R8/R9 power-down with work in flight and a pending request
    wr('h0C0, 32'h0000_8001);
    wr('h0C4, 32'h0000_8005);
    wr('h034, 32'h0000_0001);
    idle(3);
    wr('h034, 32'h0000_0002);
    wr('h040, 32'h0000_0008);
    rd('h02C, "R8", 32'h40);
    rd('h040, "R8", 32'h8);
    wr('h034, 32'h0000_0008);
    rd('h030, "R9", 32'h3);
    idle(60);
    rd('h030, "R9", 32'h2);
    rd('h100, "R3", {20'h0, a1(1)});
    rd('h02C, "R8", 0);
    wr('h040, 32'h0);
    rd('h02C, "R8", 32'h40);
    idle(4);
    rd('h030, "R9", 32'h2);
    wait_clear(1, 200, n);
    rd('h104, "R9", {20'h0, a1(5)});
    rd('h02C, "R8", 0);

    idle(4);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule